// File: doc/BRIEF.md
# Overlapped-Fetch Multicycle Instruction Sequencer

This block is the control and datapath core of a small 8-bit accumulator processor subset. It holds an accumulator, an index register, four condition flags (negative, overflow, zero, carry) and a program counter. A single byte-wide memory port is read once per cycle: the core drives an address, and the read data must be valid within that same cycle. A per-instruction cycle counter steps each instruction through its phases. The supported operations are load-immediate into the accumulator, decrement of the index register, and eight conditional relative branches on the flags. Any other opcode behaves as a one-cycle no-op.

Each instruction starts by fetching its opcode at the program counter. In that cycle the counter also moves past any operand, so a one-byte operand is read later from the counter minus one. A single-cycle operation does its work in the same cycle as the next opcode fetch. The cycle counter then restarts at 1, not 0. Branches read the flags one cycle after their own fetch, so a decrement right before a branch is seen correctly. An untaken branch costs 2 cycles. A taken branch costs 3 cycles, and in its last cycle it reads the signed offset and adds it to the counter.

Top module: `seq_core`

## Requirements
- R1: After reset, `pc_out` equals parameter RESET_PC, `acc_out` is 0, `x_out` equals RESET_X and `flags_out` equals RESET_FLAGS. The flag bits are N at bit 3, V at bit 2, Z at bit 1 and C at bit 0. The first cycle after reset fetches an opcode at RESET_PC.
- R2: In every opcode-fetch cycle, `opcode_fetch` is 1 and `mem_addr` equals the program counter. The counter then advances by 2 for load-immediate and branch opcodes, and by 1 for all others.
- R3: Opcode 0xA9 (load-immediate) reads the byte at the counter minus one in its second cycle and places it in the accumulator. N is set to result bit 7 and Z to (result == 0); V and C keep their values. The next fetch comes 2 cycles after this opcode's fetch.
- R4: Opcode 0xCA (decrement) subtracts 1 from the index register modulo 256 and updates N and Z the same way as R3, leaving V and C unchanged. Its work shares a cycle with the next opcode fetch, so the next fetch follows 1 cycle after its own.
- R5: Every opcode that is neither 0xA9, 0xCA nor a branch changes no register or flag, and the next fetch follows in the next cycle.
- R6: A branch opcode has low five bits 10000. Bits 7:6 select the flag (00 N, 01 V, 10 C, 11 Z). The branch is taken when that flag equals bit 5.
- R7: A branch tests the flags in the cycle after its own fetch, so it sees flags written by an instruction whose final cycle was merged with the branch fetch.
- R8: An untaken branch fetches the next opcode 2 cycles after its own fetch, at the address just past its offset byte.
- R9: A taken branch fetches the next opcode 3 cycles after its own fetch. The target is the address just past the offset byte plus the offset sign-extended from 8 to 16 bits, so both forward and backward targets are reached.
- R10: The per-instruction cycle counter never exceeds 2. It returns to 0 after a load-immediate or a taken branch, and to 1 after any cycle merged with a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory read address for this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle as the address |
| opcode_fetch | output | 1 | High in every cycle that latches an opcode |
| pc_out | output | ADDR_W | Current program counter |
| acc_out | output | DATA_W | Accumulator |
| x_out | output | DATA_W | Index register |
| flags_out | output | 4 | Flags N, V, Z, C at bits 3..0 |

## Verification
The bench builds the core with RESET_PC = 0x0010, RESET_X = 1 and RESET_FLAGS = 0101 (V and C set, N and Z clear). With V and C preset, the overflow and carry branches can be exercised both ways, even though no supported instruction writes those flags. Starting the index at 1 lets a single decrement produce zero. That puts the Z-set case directly in front of a branch-on-equal, which tests the late flag sampling. Starting Z clear means a branch that tested the flags one cycle too early would go the wrong way.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      CLS_NOP = 2'd0,
      CLS_LDI = 2'd1,
      CLS_DEC = 2'd2,
      CLS_BR  = 2'd3
   } op_cls_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_V = 2;
   localparam int FLAG_Z = 1;
   localparam int FLAG_C = 0;
   localparam int NUM_FLAGS = 4;

   localparam logic [7:0] OPC_LDI = 8'hA9;
   localparam logic [7:0] OPC_DEC = 8'hCA;
   localparam logic [4:0] BR_TAG  = 5'b10000;

   // branch selector code -> flag bit position
   function automatic int sel_to_flag(input int sel);
      case (sel)
         0:       return FLAG_N;
         1:       return FLAG_V;
         2:       return FLAG_C;
         default: return FLAG_Z;
      endcase
   endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
(
   input  logic [7:0] opc,
   output op_cls_e    cls
);
   always_comb begin
      if (opc == OPC_LDI)             cls = CLS_LDI;
      else if (opc == OPC_DEC)        cls = CLS_DEC;
      else if (opc[4:0] == BR_TAG)    cls = CLS_BR;
      else                            cls = CLS_NOP;
   end
endmodule

// File: rtl/seq_branch_cond.sv
module seq_branch_cond
   import seq_pkg::*;
#(
   parameter int N_SEL = 4
) (
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [1:0]           sel,
   input  logic                 want,
   output logic                 take
);
   logic [N_SEL-1:0] hit;

   generate
      if (N_SEL != 4) begin : g_bad_sel
         $error("seq_branch_cond: N_SEL must be 4");
      end
      for (genvar g = 0; g < N_SEL; g++) begin : g_sel
         localparam int FIDX = sel_to_flag(g);
         assign hit[g] = (flags[FIDX] == want);
      end
   endgenerate

   assign take = hit[sel];
endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
   parameter int W = 8
) (
   input  logic         dec_sel,
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] imm,
   output logic [W-1:0] res,
   output logic         res_n,
   output logic         res_z
);
   generate
      if (W < 2) begin : g_bad_w
         $error("seq_alu: W must be at least 2");
      end
   endgenerate

   assign res   = dec_sel ? (x_in - W'(1)) : imm;
   assign res_n = res[W-1];
   assign res_z = (res == '0);
endmodule

// File: rtl/seq_core.sv
module seq_core
   import seq_pkg::*;
#(
   parameter int                  ADDR_W      = 16,
   parameter int                  DATA_W      = 8,
   parameter int                  CYC_W       = 2,
   parameter logic [ADDR_W-1:0]   RESET_PC    = '0,
   parameter logic [DATA_W-1:0]   RESET_X     = '0,
   parameter logic [3:0]          RESET_FLAGS = 4'b0000
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              opcode_fetch,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] x_out,
   output logic [3:0]        flags_out
);
   localparam int EXT_W = ADDR_W - DATA_W;
   localparam logic [CYC_W-1:0] CYC_FETCH = CYC_W'(0);
   localparam logic [CYC_W-1:0] CYC_EXEC  = CYC_W'(1);
   localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(2);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("seq_core: DATA_W must be 8");
      end
      if (EXT_W < 1) begin : g_bad_addr
         $error("seq_core: ADDR_W must exceed DATA_W");
      end
      if (CYC_W < 2) begin : g_bad_cyc
         $error("seq_core: CYC_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0]    pc_q;
   logic [DATA_W-1:0]    ir_q, a_q, x_q;
   logic [NUM_FLAGS-1:0] fl_q;
   logic [CYC_W-1:0]     cyc_q;
   logic                 take_q;

   op_cls_e ir_cls, fetch_cls;
   logic    take_now;

   seq_decode u_dec_ir    (.opc(ir_q[7:0]),      .cls(ir_cls));
   seq_decode u_dec_fetch (.opc(mem_rdata[7:0]), .cls(fetch_cls));

   seq_branch_cond #(.N_SEL(4)) u_cond (
      .flags (fl_q),
      .sel   (ir_q[7:6]),
      .want  (ir_q[5]),
      .take  (take_now)
   );

   // cycle-role decode
   logic in_exec, in_last;
   logic is_ldi, is_dec, is_br, is_nop;
   logic skip_now, end_now, fetch_now, op_read;

   assign in_exec = (cyc_q == CYC_EXEC);
   assign in_last = (cyc_q == CYC_LAST);
   assign is_ldi  = (ir_cls == CLS_LDI);
   assign is_dec  = (ir_cls == CLS_DEC);
   assign is_br   = (ir_cls == CLS_BR);
   assign is_nop  = (ir_cls == CLS_NOP);

   assign skip_now  = (in_exec && (is_dec || is_nop)) || (in_last && is_br && !take_q);
   assign end_now   = (in_exec && is_ldi) || (in_last && is_br && take_q);
   assign fetch_now = (cyc_q == CYC_FETCH) || skip_now;
   assign op_read   = end_now;

   // address and PC arithmetic
   logic [ADDR_W-1:0] pc_m1, off_sx, fetch_len, pc_next;

   assign pc_m1     = pc_q - ADDR_W'(1);
   assign off_sx    = {{EXT_W{mem_rdata[DATA_W-1]}}, mem_rdata};
   assign fetch_len = ((fetch_cls == CLS_LDI) || (fetch_cls == CLS_BR)) ? ADDR_W'(2) : ADDR_W'(1);
   assign mem_addr  = op_read ? pc_m1 : pc_q;

   always_comb begin
      if (fetch_now)                    pc_next = pc_q + fetch_len;
      else if (in_last && is_br && take_q) pc_next = pc_q + off_sx;
      else                              pc_next = pc_q;
   end

   // register writes
   logic              wr_a, wr_x;
   logic [DATA_W-1:0] alu_res;
   logic              alu_n, alu_z;

   assign wr_a = in_exec && is_ldi;
   assign wr_x = in_exec && is_dec;

   seq_alu #(.W(DATA_W)) u_alu (
      .dec_sel (wr_x),
      .x_in    (x_q),
      .imm     (mem_rdata),
      .res     (alu_res),
      .res_n   (alu_n),
      .res_z   (alu_z)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         ir_q   <= '0;
         a_q    <= '0;
         x_q    <= RESET_X;
         fl_q   <= RESET_FLAGS;
         cyc_q  <= CYC_FETCH;
         take_q <= 1'b0;
      end else begin
         pc_q <= pc_next;
         if (fetch_now) begin
            ir_q  <= mem_rdata;
            cyc_q <= CYC_EXEC;
         end else if (end_now) begin
            cyc_q <= CYC_FETCH;
         end else begin
            cyc_q <= cyc_q + CYC_W'(1);
         end
         if (in_exec && is_br) take_q <= take_now;
         if (wr_a) a_q <= alu_res;
         if (wr_x) x_q <= alu_res;
         if (wr_a || wr_x) begin
            fl_q[FLAG_N] <= alu_n;
            fl_q[FLAG_Z] <= alu_z;
         end
      end
   end

   assign opcode_fetch = fetch_now;
   assign pc_out       = pc_q;
   assign acc_out      = a_q;
   assign x_out        = x_q;
   assign flags_out    = fl_q;

   // assertions
   AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q <= CYC_LAST);                                                    // R10

   AST_LDI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && is_ldi) |=> (cyc_q == CYC_FETCH && a_q == $past(mem_rdata))); // R3

   AST_VC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && (is_ldi || is_dec)) |=>
         (fl_q[FLAG_V] == $past(fl_q[FLAG_V]) && fl_q[FLAG_C] == $past(fl_q[FLAG_C]))); // R3

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && is_dec) |=> (x_q == $past(x_q) - DATA_W'(1) && cyc_q == CYC_EXEC)); // R4

   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && is_nop) |=> ($stable(a_q) && $stable(x_q) && $stable(fl_q))); // R5

   AST_NT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_last && is_br && !take_q) |=> (cyc_q == CYC_EXEC && ir_q == $past(mem_rdata))); // R8

   AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_last && is_br && take_q) |=> (pc_q == $past(pc_q) + $past(off_sx))); // R9

endmodule

// File: tb/seq_core_test.sv
module seq_core_test;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam logic [15:0] RPC = 16'h0010;
   localparam logic [7:0]  RX  = 8'h01;
   localparam logic [3:0]  RFL = 4'b0101;
   localparam int LOGN = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic          opcode_fetch;
   logic [AW-1:0] pc_out;
   logic [DW-1:0] acc_out, x_out;
   logic [3:0]    flags_out;

   logic [7:0] mem [0:255];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic        log_f    [0:LOGN-1];
   logic [15:0] log_addr [0:LOGN-1];
   logic [15:0] log_pc   [0:LOGN-1];
   logic [7:0]  log_a    [0:LOGN-1];
   logic [7:0]  log_x    [0:LOGN-1];
   logic [3:0]  log_fl   [0:LOGN-1];

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];

   seq_core #(
      .ADDR_W(AW), .DATA_W(DW), .CYC_W(2),
      .RESET_PC(RPC), .RESET_X(RX), .RESET_FLAGS(RFL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .opcode_fetch(opcode_fetch), .pc_out(pc_out), .acc_out(acc_out),
      .x_out(x_out), .flags_out(flags_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_fetch(input int idx, input logic [15:0] addr, input string tag);
      chk(log_f[idx] && log_addr[idx] == addr, tag, {15'd0, log_f[idx], log_addr[idx]}, {15'd0, 1'b1, addr});
   endtask

   task automatic chk_idle(input int idx, input string tag);
      chk(!log_f[idx], tag, {31'd0, log_f[idx]}, 32'd0);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'hEA;
   endtask

   task automatic run_prog(input int n);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < n; k++) begin
         if (k > 0) @(negedge clk);
         #1;
         log_f[k]    = opcode_fetch;
         log_addr[k] = mem_addr;
         log_pc[k]   = pc_out;
         log_a[k]    = acc_out;
         log_x[k]    = x_out;
         log_fl[k]   = flags_out;
      end
   endtask

   task automatic test_reset();
      clear_mem();
      run_prog(1);
      chk(log_pc[0] == RPC, "R1 pc after reset", log_pc[0], RPC);
      chk(log_a[0] == 8'h00, "R1 acc after reset", log_a[0], 0);
      chk(log_x[0] == RX, "R1 x after reset", log_x[0], RX);
      chk(log_fl[0] == RFL, "R1 flags after reset", log_fl[0], RFL);
      chk_fetch(0, RPC, "R1 first fetch at reset pc");
   endtask

   task automatic test_load_nop();
      clear_mem();
      mem[8'h10] = 8'hA9; mem[8'h11] = 8'h80;
      mem[8'h12] = 8'hA9; mem[8'h13] = 8'h00;
      mem[8'h14] = 8'h02; mem[8'h15] = 8'h02;
      run_prog(8);
      chk_fetch(0, 16'h0010, "R2 fetch ldi");
      chk_idle(1, "R3 ldi operand cycle");
      chk(log_addr[1] == 16'h0011, "R3 operand at pc-1", log_addr[1], 16'h0011);
      chk_fetch(2, 16'h0012, "R3 next fetch two cycles on");
      chk(log_a[2] == 8'h80, "R3 acc loaded", log_a[2], 8'h80);
      chk(log_fl[2] == 4'b1101, "R3 N set V C kept", log_fl[2], 4'b1101);
      chk_idle(3, "R3 second ldi operand cycle");
      chk_fetch(4, 16'h0014, "R2 fetch unknown opcode");
      chk(log_a[4] == 8'h00 && log_fl[4] == 4'b0111, "R3 zero load sets Z",
          {log_a[4], log_fl[4]}, {8'h00, 4'b0111});
      chk_fetch(5, 16'h0015, "R5 unknown opcode one cycle");
      chk_fetch(6, 16'h0016, "R5 second unknown opcode one cycle");
      chk(log_a[7] == 8'h00 && log_x[7] == RX && log_fl[7] == 4'b0111, "R5 no register change",
          {log_a[7], log_x[7], log_fl[7]}, {8'h00, RX, 4'b0111});
   endtask

   task automatic test_dex_branch();
      clear_mem();
      mem[8'h10] = 8'hCA;
      mem[8'h11] = 8'hF0; mem[8'h12] = 8'h05;   // Z=1 branch, +5
      mem[8'h18] = 8'hD0; mem[8'h19] = 8'h02;   // Z=0 branch
      mem[8'h1A] = 8'hA9; mem[8'h1B] = 8'h7F;
      mem[8'h1C] = 8'h30; mem[8'h1D] = 8'hFE;   // N=1 branch
      mem[8'h1E] = 8'h10; mem[8'h1F] = 8'hF0;   // N=0 branch, -16
      run_prog(15);
      chk_fetch(0, 16'h0010, "R2 fetch dec");
      chk_fetch(1, 16'h0011, "R4 merged fetch after dec");
      chk(log_x[2] == 8'h00 && log_fl[2] == 4'b0111, "R4 dec to zero flags",
          {log_x[2], log_fl[2]}, {8'h00, 4'b0111});
      chk_idle(2, "R7 branch test cycle");
      chk_idle(3, "R9 taken branch offset cycle");
      chk_fetch(4, 16'h0018, "R7 R9 branch sees dec Z and jumps forward");
      chk_idle(5, "R8 untaken branch test cycle");
      chk_fetch(6, 16'h001A, "R8 untaken after two cycles");
      chk_fetch(8, 16'h001C, "R3 ldi two cycles");
      chk(log_a[8] == 8'h7F && log_fl[8] == 4'b0101, "R3 positive load clears N Z",
          {log_a[8], log_fl[8]}, {8'h7F, 4'b0101});
      chk_fetch(10, 16'h001E, "R6 R8 minus-set branch untaken");
      chk_idle(11, "R9 backward test cycle");
      chk_idle(12, "R9 backward offset cycle");
      chk_fetch(13, 16'h0010, "R6 R9 plus branch jumps backward");
      chk(log_x[14] == 8'h00, "R4 x before second dec", log_x[14], 8'h00);
   endtask

   task automatic test_vc_branch();
      clear_mem();
      mem[8'h10] = 8'h70; mem[8'h11] = 8'h02;   // V=1 branch, taken
      mem[8'h14] = 8'h90; mem[8'h15] = 8'h02;   // C=0 branch, untaken
      mem[8'h16] = 8'hB0; mem[8'h17] = 8'h00;   // C=1 branch, taken, offset 0
      mem[8'h18] = 8'h50; mem[8'h19] = 8'h04;   // V=0 branch, untaken
      mem[8'h1A] = 8'hA9; mem[8'h1B] = 8'h00;
      run_prog(13);
      chk_fetch(3, 16'h0014, "R6 R9 overflow-set branch taken");
      chk_idle(4, "R8 carry-clear test cycle");
      chk_fetch(5, 16'h0016, "R6 R8 carry-clear branch untaken");
      chk_fetch(8, 16'h0018, "R9 zero offset target");
      chk_fetch(10, 16'h001A, "R6 R8 overflow-clear branch untaken");
      chk_fetch(12, 16'h001C, "R3 final ldi");
      chk(log_a[12] == 8'h00 && log_fl[12] == 4'b0111, "R3 V C kept across load",
          {log_a[12], log_fl[12]}, {8'h00, 4'b0111});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_load_nop();
      test_dex_branch();
      test_vc_branch();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule